// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block produces the three clocks of a two-channel serial audio link from a single fixed 32 MHz reference, which is also its own clock. An integer divider taken from a fixed menu turns the reference into the oversampling master clock. A frame ratio taken from a second menu sets how many master clock periods make one sample frame. The bit clock is placed inside each frame according to the sample width, so that every frame carries exactly two channel slots of that width. Because both menus hold whole numbers only, common audio rates come out close but not exact. For example, dividers 21 and 32 give about 47.6 kHz, and dividers 15 and 48 give about 44.4 kHz. Other pairs are exact: 125 with 32 gives 8 kHz.

In master mode the block drives all three clocks. In slave mode it drives no master clock, and the bit and frame clocks are taken from external pins and passed through a short synchronizer. Configuration inputs are sampled only when the generator starts and at each frame boundary. A setting that cannot work is flagged, and the generator does not run while it is in force.

Top module: `audio_clkgen`

## Requirements
- R1: In master mode with the generator running, `mck_o` has a period of N reference cycles. N is chosen by `div_sel`: index 0..12 selects 8, 10, 11, 15, 16, 21, 23, 30, 31, 32, 42, 63, 125 in that order, and 13..15 are invalid.
- R2: Each master clock period starts high. It is high for floor(N/2) reference cycles and low for the rest, so an odd N has the longer low phase.
- R3: One frame lasts N×R reference cycles. R is chosen by `ratio_sel`: index 0..8 selects 32, 48, 64, 96, 128, 192, 256, 384, 512 in that order, and 9..15 are invalid.
- R4: `width_sel` 0, 1, 2 selects a sample width W of 8, 16, 24 bits, and 3 is invalid. `sck_o` makes exactly 2×W rising edges in each frame.
- R5: `lrck_o` is low for the first (left) half of each frame and high for the second (right) half, exactly N×R/2 cycles each. It changes only in a cycle where `sck_o` falls, and a frame begins at the falling edge of `lrck_o`.
- R6: While `mck_en` is low, `mck_o` stays low, and the bit and frame clocks keep running.
- R7: With `master_mode` low and `enable` high, `mck_o` stays low. `sck_o` and `lrck_o` follow `ext_sck` and `ext_lrck` two clock edges after they change.
- R8: A configuration is invalid if any index is out of range or if R < 2×W. In that case `cfg_err` is high one cycle after the configuration is presented (with `enable` and master mode), and the generator does not start. A generator that is already running stops at the next frame boundary.
- R9: A change of `div_sel`, `ratio_sel` or `width_sel` while running does not alter the frame in progress. It takes effect from the next frame boundary.
- R10: After reset, and one cycle after `enable` goes low, all clock outputs and `cfg_err` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32 MHz reference clock |
| rst | input | 1 | synchronous active-high reset |
| enable | input | 1 | block enable |
| master_mode | input | 1 | 1 = generate clocks, 0 = follow external clocks |
| mck_en | input | 1 | gate for the master clock output |
| div_sel | input | 4 | master clock divider index |
| ratio_sel | input | 4 | frame ratio index |
| width_sel | input | 2 | sample width index |
| ext_sck | input | 1 | external bit clock (slave mode) |
| ext_lrck | input | 1 | external frame clock (slave mode) |
| mck_o | output | 1 | master clock |
| sck_o | output | 1 | bit clock |
| lrck_o | output | 1 | frame (channel select) clock |
| cfg_err | output | 1 | current configuration is invalid |

## Verification
The bench uses odd dividers (11, 125) to check the high/low split. A design that rounded the high phase up would show 6/5 instead of 5/6. It also uses ratios that are not a power-of-two multiple of the bit count (48 with 16-bit, 512 with 24-bit), where a bit clock spacing that drifts would give the wrong count of rising edges or a frame clock edge off the bit clock's falling edge. One scenario changes the divider halfway through a frame. A design that applied the change at once would cut the right half short of 128 cycles. The cases R = 2×W (allowed) and 24-bit with ratio 32 (rejected) probe the validity limit. A design with an off-by-one there would either flag the legal setting or run the illegal one.

// File: rtl/audio_clkgen_pkg.sv
package audio_clkgen_pkg;
  localparam int DIV_SEL_W = 4;
  localparam int RAT_SEL_W = 4;
  localparam int WID_SEL_W = 2;
  localparam int DIV_W     = 7;   // largest divider 125
  localparam int RAT_W     = 10;  // largest ratio 512
  localparam int BITS_W    = 5;   // largest sample width 24
  localparam int FRAME_W   = DIV_W + RAT_W;
  localparam int HB_W      = BITS_W + 2; // half-bit slots per frame = 4*W

  // Master clock divider menu; 0 marks an unused index.
  function automatic logic [DIV_W-1:0] mck_div_of(input logic [DIV_SEL_W-1:0] s);
    case (s)
      4'd0:  return DIV_W'(8);
      4'd1:  return DIV_W'(10);
      4'd2:  return DIV_W'(11);
      4'd3:  return DIV_W'(15);
      4'd4:  return DIV_W'(16);
      4'd5:  return DIV_W'(21);
      4'd6:  return DIV_W'(23);
      4'd7:  return DIV_W'(30);
      4'd8:  return DIV_W'(31);
      4'd9:  return DIV_W'(32);
      4'd10: return DIV_W'(42);
      4'd11: return DIV_W'(63);
      4'd12: return DIV_W'(125);
      default: return '0;
    endcase
  endfunction

  // Frame ratio menu; 0 marks an unused index.
  function automatic logic [RAT_W-1:0] ratio_of(input logic [RAT_SEL_W-1:0] s);
    case (s)
      4'd0: return RAT_W'(32);
      4'd1: return RAT_W'(48);
      4'd2: return RAT_W'(64);
      4'd3: return RAT_W'(96);
      4'd4: return RAT_W'(128);
      4'd5: return RAT_W'(192);
      4'd6: return RAT_W'(256);
      4'd7: return RAT_W'(384);
      4'd8: return RAT_W'(512);
      default: return '0;
    endcase
  endfunction

  function automatic logic [BITS_W-1:0] bits_of(input logic [WID_SEL_W-1:0] s);
    case (s)
      2'd0: return BITS_W'(8);
      2'd1: return BITS_W'(16);
      2'd2: return BITS_W'(24);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/audio_clkgen_mck_div.sv
module audio_clkgen_mck_div #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,      // generator runs next cycle
  input  logic             sync0,   // restart the period next cycle
  input  logic             gate,    // output enable
  input  logic [DIV_W-1:0] div_n,
  output logic             mck
);
  logic [DIV_W-1:0] cnt_q, cnt_n, half;

  assign half  = div_n >> 1;
  assign cnt_n = (cnt_q == div_n - DIV_W'(1)) ? '0 : cnt_q + DIV_W'(1);

  always_ff @(posedge clk) begin
    if (rst || !go) begin
      cnt_q <= '0;
      mck   <= 1'b0;
    end else if (sync0) begin
      cnt_q <= '0;
      mck   <= gate;
    end else begin
      cnt_q <= cnt_n;
      mck   <= gate && (cnt_n < half);
    end
  end

  // R1: phase counter never leaves the selected period
  a_r1_cnt_in_period: assert property (@(posedge clk) disable iff (rst)
    $past(go) |-> (cnt_q < div_n));
endmodule

// File: rtl/audio_clkgen_frame_seq.sv
module audio_clkgen_frame_seq #(
  parameter int FRAME_W = 17,
  parameter int HB_W    = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go,
  input  logic               sync0,
  input  logic               run_now,
  input  logic [FRAME_W-1:0] frame_len,  // N*R reference cycles
  input  logic [HB_W-1:0]    step,       // 4*W half-bit slots
  output logic               sck,
  output logic               lrck,
  output logic               boundary
);
  logic [FRAME_W-1:0] acc_q, acc_n;
  logic [FRAME_W:0]   acc_sum;
  logic [HB_W-1:0]    hb_q, hb_n, hb_last, half_pt;
  logic               adv, wrap;

  // Rate accumulator: exactly step advances per frame_len cycles, at most one per cycle.
  assign acc_sum = {1'b0, acc_q} + {{(FRAME_W+1-HB_W){1'b0}}, step};
  assign adv     = acc_sum >= {1'b0, frame_len};
  assign acc_n   = adv ? FRAME_W'(acc_sum - {1'b0, frame_len}) : acc_sum[FRAME_W-1:0];
  assign hb_last = step - HB_W'(1);
  assign half_pt = step >> 1;
  assign wrap    = (hb_q == hb_last);
  assign hb_n    = adv ? (wrap ? '0 : hb_q + HB_W'(1)) : hb_q;
  assign boundary = run_now && adv && wrap;

  always_ff @(posedge clk) begin
    if (rst || !go) begin
      acc_q <= '0;
      hb_q  <= '0;
      sck   <= 1'b0;
      lrck  <= 1'b0;
    end else if (sync0) begin
      acc_q <= '0;
      hb_q  <= '0;
      sck   <= 1'b0;
      lrck  <= 1'b0;
    end else begin
      acc_q <= acc_n;
      hb_q  <= hb_n;
      sck   <= hb_n[0];
      lrck  <= (hb_n >= half_pt);
    end
  end

  // R5: frame clock moves only together with a falling bit clock
  a_r5_lrck_on_sck_fall: assert property (@(posedge clk) disable iff (rst)
    ($past(go) && $past(go, 2) && (lrck != $past(lrck))) |-> ($past(sck) && !sck));
  // R4: half-bit index stays inside the frame
  a_r4_slot_range: assert property (@(posedge clk) disable iff (rst)
    $past(go) |-> (hb_q < step));
endmodule

// File: rtl/audio_clkgen_sync.sv
module audio_clkgen_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
  import audio_clkgen_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 enable,
  input  logic                 master_mode,
  input  logic                 mck_en,
  input  logic [DIV_SEL_W-1:0] div_sel,
  input  logic [RAT_SEL_W-1:0] ratio_sel,
  input  logic [WID_SEL_W-1:0] width_sel,
  input  logic                 ext_sck,
  input  logic                 ext_lrck,
  output logic                 mck_o,
  output logic                 sck_o,
  output logic                 lrck_o,
  output logic                 cfg_err
);
  localparam int SYNC_STAGES = 2;

  logic [DIV_W-1:0]   n_l, n_q;
  logic [RAT_W-1:0]   r_l;
  logic [BITS_W-1:0]  w_l, w_q;
  logic [FRAME_W-1:0] f_l, f_q;
  logic               live_ok, active, run_q, run_d, load, boundary;
  logic               gen_sck, gen_lrck;
  logic [1:0]         slv;

  assign n_l = mck_div_of(div_sel);
  assign r_l = ratio_of(ratio_sel);
  assign w_l = bits_of(width_sel);
  assign f_l = {{RAT_W{1'b0}}, n_l} * {{DIV_W{1'b0}}, r_l};
  assign live_ok = (n_l != '0) && (r_l != '0) && (w_l != '0) &&
                   (r_l >= {{(RAT_W-BITS_W-1){1'b0}}, w_l, 1'b0});
  assign active  = enable && master_mode;

  // Configuration is taken only at start or at a frame boundary.
  assign load = active && live_ok && (!run_q || boundary);

  always_comb begin
    if (!active)       run_d = 1'b0;
    else if (!run_q)   run_d = live_ok;
    else if (boundary) run_d = live_ok;
    else               run_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      n_q     <= '0;
      w_q     <= '0;
      f_q     <= '0;
      cfg_err <= 1'b0;
    end else begin
      run_q   <= run_d;
      cfg_err <= active && !live_ok;
      if (load) begin
        n_q <= n_l;
        w_q <= w_l;
        f_q <= f_l;
      end
    end
  end

  audio_clkgen_mck_div #(.DIV_W(DIV_W)) u_mck (
    .clk(clk), .rst(rst), .go(run_d), .sync0(load), .gate(mck_en),
    .div_n(n_q), .mck(mck_o)
  );

  audio_clkgen_frame_seq #(.FRAME_W(FRAME_W), .HB_W(HB_W)) u_seq (
    .clk(clk), .rst(rst), .go(run_d), .sync0(load), .run_now(run_q),
    .frame_len(f_q), .step({w_q, 2'b00}),
    .sck(gen_sck), .lrck(gen_lrck), .boundary(boundary)
  );

  audio_clkgen_sync #(.W(2), .STAGES(SYNC_STAGES)) u_slv (
    .clk(clk), .clr(rst || !(enable && !master_mode)),
    .d({ext_lrck, ext_sck}), .q(slv)
  );

  // Each source is held at zero while the other mode is in force.
  assign sck_o  = gen_sck | slv[0];
  assign lrck_o = gen_lrck | slv[1];

  // R7: no master clock in slave mode
  a_r7_slave_no_mck: assert property (@(posedge clk) disable iff (rst)
    !master_mode |=> !mck_o);
  // R10: disabling silences every output
  a_r10_disable_quiet: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !(mck_o || sck_o || lrck_o || cfg_err));
  // R9: latched settings only move on a load
  a_r9_cfg_held: assert property (@(posedge clk) disable iff (rst)
    (run_q && !$past(load)) |-> ($stable(n_q) && $stable(f_q) && $stable(w_q)));
  // R8: an invalid setting never starts the generator
  a_r8_invalid_idle: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !live_ok) |=> !run_q);
endmodule

// File: tb/audio_clkgen_test.sv
module audio_clkgen_test;
  localparam int CLK_P = 10;
  localparam int WDOG  = 190000;

  logic       clk = 1'b0, rst = 1'b1;
  logic       enable = 0, master_mode = 1, mck_en = 1;
  logic [3:0] div_sel = 0, ratio_sel = 0;
  logic [1:0] width_sel = 1;
  logic       ext_sck = 0, ext_lrck = 0;
  logic       mck_o, sck_o, lrck_o, cfg_err;
  int checks = 0, failures = 0;

  always #(CLK_P/2) clk = ~clk;

  audio_clkgen uut (
    .clk(clk), .rst(rst), .enable(enable), .master_mode(master_mode), .mck_en(mck_en),
    .div_sel(div_sel), .ratio_sel(ratio_sel), .width_sel(width_sel),
    .ext_sck(ext_sck), .ext_lrck(ext_lrck),
    .mck_o(mck_o), .sck_o(sck_o), .lrck_o(lrck_o), .cfg_err(cfg_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic set_cfg(input int d, input int r, input int w);
    div_sel = 4'(d); ratio_sel = 4'(r); width_sel = 2'(w);
  endtask

  // Measures one full frame starting at a falling edge of lrck_o.
  task automatic measure_frame(output int flen, output int lowlen,
                               output int rises, output int misalign);
    logic pl, ps;
    pl = lrck_o; ps = sck_o;
    forever begin
      @(negedge clk);
      if (pl && !lrck_o) break;
      pl = lrck_o; ps = sck_o;
    end
    flen = 0; lowlen = 0; rises = 0; misalign = 0;
    if (!(ps && !sck_o)) misalign++;
    forever begin
      flen++;
      if (!lrck_o) lowlen++;
      pl = lrck_o; ps = sck_o;
      @(negedge clk);
      if (!ps && sck_o) rises++;
      if ((pl != lrck_o) && !(ps && !sck_o)) misalign++;
      if (pl && !lrck_o) break;
    end
  endtask

  task automatic measure_mck(output int hi, output int lo);
    logic pm;
    pm = mck_o;
    forever begin
      @(negedge clk);
      if (!pm && mck_o) break;
      pm = mck_o;
    end
    hi = 0; lo = 0;
    while (mck_o) begin hi++; @(negedge clk); end
    while (!mck_o) begin lo++; @(negedge clk); end
  endtask

  task automatic test_reset();
    chk("R10 reset mck", int'(mck_o), 0);
    chk("R10 reset sck", int'(sck_o), 0);
    chk("R10 reset lrck", int'(lrck_o), 0);
    chk("R10 reset cfg_err", int'(cfg_err), 0);
  endtask

  task automatic frame_case(input string tag, input int d, input int r, input int w,
                            input int nf, input int bits);
    int fl, lo, ri, mis;
    set_cfg(d, r, w);
    measure_frame(fl, lo, ri, mis);
    chk({"R3 frame length ", tag}, fl, nf);
    chk({"R5 left half ", tag}, lo, nf / 2);
    chk({"R4 sck rises ", tag}, ri, 2 * bits);
    chk({"R5 lrck aligned to sck fall ", tag}, mis, 0);
  endtask

  task automatic mck_case(input string tag, input int d, input int n);
    int fl, lo, ri, mis, hi, low;
    set_cfg(d, 0, 1);
    measure_frame(fl, lo, ri, mis);
    measure_mck(hi, low);
    chk({"R1 mck period ", tag}, hi + low, n);
    chk({"R2 mck high ", tag}, hi, n / 2);
  endtask

  task automatic test_mck_gate();
    int highs = 0, rises = 0;
    logic ps;
    @(negedge clk); mck_en = 0;
    @(negedge clk);
    ps = sck_o;
    repeat (64) begin
      @(negedge clk);
      if (mck_o) highs++;
      if (!ps && sck_o) rises++;
      ps = sck_o;
    end
    chk("R6 mck gated low", highs, 0);
    chk("R6 sck still running", int'(rises > 0), 1);
    mck_en = 1;
  endtask

  task automatic test_midframe_change();
    int fl, lo, ri, mis, cnt;
    logic pl;
    set_cfg(0, 0, 1);                 // 8 x 32 = 256
    measure_frame(fl, lo, ri, mis);
    pl = lrck_o;
    forever begin
      @(negedge clk);
      if (!pl && lrck_o) break;
      pl = lrck_o;
    end
    set_cfg(1, 0, 1);                 // 10 x 32 = 320, pending
    cnt = 0;
    while (lrck_o) begin cnt++; @(negedge clk); end
    chk("R9 current frame keeps old right half", cnt, 128);
    measure_frame(fl, lo, ri, mis);
    chk("R9 next frame uses new setting", fl, 320);
  endtask

  task automatic test_invalid();
    int act = 0, fl, lo, ri, mis;
    @(negedge clk); enable = 0;
    @(negedge clk); set_cfg(0, 0, 2); enable = 1;   // 24-bit with ratio 32
    @(negedge clk); @(negedge clk);
    chk("R8 ratio below 2W flagged", int'(cfg_err), 1);
    repeat (300) begin
      @(negedge clk);
      if (mck_o || sck_o || lrck_o) act++;
    end
    chk("R8 idle on invalid setting", act, 0);
    set_cfg(13, 0, 1);
    @(negedge clk); @(negedge clk);
    chk("R8 divider index 13 flagged", int'(cfg_err), 1);
    set_cfg(0, 0, 1);
    @(negedge clk); @(negedge clk);
    chk("R8 flag clears on valid setting", int'(cfg_err), 0);
    measure_frame(fl, lo, ri, mis);
    chk("R8 restart frame length", fl, 256);
  endtask

  task automatic test_slave();
    int highs = 0;
    @(negedge clk); master_mode = 0; ext_sck = 0; ext_lrck = 0;
    repeat (3) @(negedge clk);
    ext_sck = 1; ext_lrck = 1;
    @(negedge clk);
    chk("R7 sck one edge later unchanged", int'(sck_o), 0);
    @(negedge clk);
    chk("R7 sck after two edges", int'(sck_o), 1);
    chk("R7 lrck after two edges", int'(lrck_o), 1);
    ext_sck = 0;
    repeat (2) @(negedge clk);
    chk("R7 sck follows low", int'(sck_o), 0);
    repeat (20) begin
      @(negedge clk);
      ext_sck = ~ext_sck;
      if (mck_o) highs++;
    end
    chk("R7 no mck in slave mode", highs, 0);
    ext_sck = 0; ext_lrck = 0;
    master_mode = 1;
  endtask

  task automatic test_disable();
    int hi, lo;
    measure_mck(hi, lo);
    while (!mck_o) @(negedge clk);
    enable = 0;
    @(negedge clk);
    chk("R10 outputs low after disable",
        int'(mck_o) + int'(sck_o) + int'(lrck_o) + int'(cfg_err), 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    test_reset();
    set_cfg(0, 0, 1); enable = 1; master_mode = 1; mck_en = 1;
    mck_case("div16", 4, 16);
    mck_case("div11", 2, 11);
    mck_case("div125", 12, 125);
    frame_case("21x32 near 48k", 5, 0, 1, 672, 16);
    frame_case("15x48 near 44.1k", 3, 1, 1, 720, 16);
    frame_case("125x32 8k 8bit", 12, 0, 0, 4000, 8);
    frame_case("8x32 125k ratio equals 2W", 0, 0, 1, 256, 16);
    frame_case("32x512 24bit", 9, 8, 2, 16384, 24);
    frame_case("11x48 24bit", 2, 1, 2, 528, 24);
    test_mck_gate();
    test_midframe_change();
    test_invalid();
    test_slave();
    test_disable();
    summary();
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    summary();
    $finish;
  end
endmodule